// File: doc/BRIEF.md
# Machine-Cycle Rate Divider with Automatic Return to Full Speed

This block derives the machine-cycle strobe of an 8-bit controller core from the oscillator clock. The strobe is a single-clock pulse that marks the last oscillator clock of each machine cycle. Software picks the cycle length through a small control register. The full-speed length is 4 clocks. Two power-saving lengths, 64 and 256 clocks, slow the core without stopping it, so code keeps running at the reduced rate. This is a different state from idle.

When the automatic return is armed, the hardware itself puts the divider back to full speed. This happens when any external interrupt request is asserted, or when a start bit shows up on the serial receive line while that line is being watched. Software does not have to act. The mode field in the control register is cleared when this happens, so a read of the register shows the change. A new length never cuts short the machine cycle already in progress. It is loaded only at the next cycle boundary.

Top module: `cycle_rate_divider`

## Requirements
- R1: After reset the mode field reads 00, the automatic return and receive watching are both off, and the strobe repeats every 4 clocks.
- R2: Mode code 00 gives a machine cycle of 4 clocks. The reserved code 01 behaves the same way. The strobe is high for exactly one clock per machine cycle.
- R3: Mode code 10 (bits 1:0 of the write data) gives a machine cycle of 64 clocks.
- R4: Mode code 11 gives a machine cycle of 256 clocks.
- R5: A new mode takes effect only at the next strobe. The machine cycle in progress when the register is written keeps its full length.
- R6: With the automatic return armed (write-data bit 2), an asserted bit of `ext_irq` clears the mode field to 00 on the next clock edge. Later machine cycles last 4 clocks.
- R7: With receive watching on (write-data bit 3) and the return armed, a falling edge on `rxd` clears the mode field to 00. This happens 3 clock edges after the edge, after a two-flop synchronizer. A rising edge does nothing.
- R8: A return to full speed leaves the automatic-return enable bit unchanged.
- R9: With the automatic return disarmed, interrupt requests and receive edges leave the mode unchanged. With receive watching off, a falling edge on `rxd` leaves the mode unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | 4 | Bits 1:0 mode, bit 2 return enable, bit 3 receive watching enable |
| ext_irq | input | IRQ_W (2) | External interrupt requests, active high, synchronous |
| rxd | input | 1 | Serial receive line, idle high, asynchronous |
| mcyc_stb | output | 1 | One-clock pulse on the last clock of each machine cycle |
| cur_mode | output | 2 | Mode field of the control register |
| ret_armed | output | 1 | Automatic-return enable bit |

## Verification
The divider is swept through all four mode codes. Each code is checked against the strobe spacing it should produce, which separates the reserved code from the two slow codes and from a wrong decoding of either mode bit. A register write in the middle of a 256-clock cycle shows whether a mode change waits for the boundary or cuts the cycle short. Return events are tried from both interrupt lines and from a receive falling edge. Each is tried again with the return disarmed, with receive watching off, and with a rising edge, which separates a real trigger from a spurious one. The check also confirms that the enable bit survives the return.

// File: rtl/crd_pkg.sv
package crd_pkg;

    typedef enum logic [1:0] {
        RATE_FULL = 2'b00,
        RATE_RSVD = 2'b01,
        RATE_SLOW = 2'b10,
        RATE_DEEP = 2'b11
    } rate_t;

    localparam int CFG_W = 4;

    typedef struct packed {
        logic  rx_watch;
        logic  ret_en;
        rate_t mode;
    } cfg_t;

    function automatic int unsigned div_of(rate_t r, int unsigned full_d,
                                           int unsigned slow_d, int unsigned deep_d);
        case (r)
            RATE_SLOW: return slow_d;
            RATE_DEEP: return deep_d;
            default:   return full_d;
        endcase
    endfunction

endpackage

// File: rtl/crd_ctrl_reg.sv
module crd_ctrl_reg
    import crd_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [CFG_W-1:0] wdata,
    input  logic             wake,
    output cfg_t             cfg
);
    cfg_t cfg_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '{rx_watch: 1'b0, ret_en: 1'b0, mode: RATE_FULL};
        end else begin
            if (we) cfg_q <= cfg_t'(wdata);
            if (wake && cfg_q.ret_en) cfg_q.mode <= RATE_FULL;
        end
    end

    assign cfg = cfg_q;

    assert_ret_clears_R6: assert property (@(posedge clk) disable iff (rst)
        (wake && cfg_q.ret_en) |=> (cfg_q.mode == RATE_FULL));

    assert_enable_kept_R8: assert property (@(posedge clk) disable iff (rst)
        (wake && !we) |=> $stable(cfg_q.ret_en));

    assert_disarmed_ignored_R9: assert property (@(posedge clk) disable iff (rst)
        (!cfg_q.ret_en && !we) |=> $stable(cfg_q.mode));
endmodule

// File: rtl/crd_wake_detect.sv
module crd_wake_detect #(
    parameter int IRQ_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IRQ_W-1:0] irq,
    input  logic             rxd,
    input  logic             rx_watch,
    output logic             wake
);
    localparam int SYNC_N = 3;

    logic [SYNC_N-1:0] rx_pipe;
    logic              rx_fall;

    always_ff @(posedge clk) begin
        if (rst) rx_pipe <= '1;
        else     rx_pipe <= {rx_pipe[SYNC_N-2:0], rxd};
    end

    assign rx_fall = rx_watch && rx_pipe[SYNC_N-1] && !rx_pipe[SYNC_N-2];
    assign wake    = (|irq) || rx_fall;

    assert_rx_gated_R9: assert property (@(posedge clk) disable iff (rst)
        !rx_watch |-> !rx_fall);

    assert_rx_edge_only_R7: assert property (@(posedge clk) disable iff (rst)
        rx_fall |=> !rx_fall);
endmodule

// File: rtl/crd_cycle_counter.sv
module crd_cycle_counter
    import crd_pkg::*;
#(
    parameter int unsigned FULL_DIV = 4,
    parameter int unsigned SLOW_DIV = 64,
    parameter int unsigned DEEP_DIV = 256
) (
    input  logic  clk,
    input  logic  rst,
    input  rate_t req_rate,
    output logic  stb
);
    localparam int CNT_W = $clog2(DEEP_DIV);

    rate_t            act_rate;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] last;

    assign last = CNT_W'(div_of(act_rate, FULL_DIV, SLOW_DIV, DEEP_DIV) - 1);
    assign stb  = (cnt == last);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt      <= '0;
            act_rate <= RATE_FULL;
        end else if (stb) begin
            cnt      <= '0;
            act_rate <= req_rate;
        end else begin
            cnt      <= cnt + 1'b1;
        end
    end

    assert_boundary_only_R5: assert property (@(posedge clk) disable iff (rst)
        !stb |=> $stable(act_rate));

    assert_single_pulse_R2: assert property (@(posedge clk) disable iff (rst)
        stb |=> !stb);

    assert_count_in_range_R4: assert property (@(posedge clk) disable iff (rst)
        cnt <= last);
endmodule

// File: rtl/cycle_rate_divider.sv
module cycle_rate_divider
    import crd_pkg::*;
#(
    parameter int unsigned FULL_DIV = 4,
    parameter int unsigned SLOW_DIV = 64,
    parameter int unsigned DEEP_DIV = 256,
    parameter int          IRQ_W    = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_we,
    input  logic [CFG_W-1:0] cfg_wdata,
    input  logic [IRQ_W-1:0] ext_irq,
    input  logic             rxd,
    output logic             mcyc_stb,
    output logic [1:0]       cur_mode,
    output logic             ret_armed
);
    cfg_t cfg;
    logic wake;

    crd_wake_detect #(.IRQ_W(IRQ_W)) u_wake (
        .clk(clk), .rst(rst), .irq(ext_irq), .rxd(rxd),
        .rx_watch(cfg.rx_watch), .wake(wake)
    );

    crd_ctrl_reg u_ctrl (
        .clk(clk), .rst(rst), .we(cfg_we), .wdata(cfg_wdata),
        .wake(wake), .cfg(cfg)
    );

    crd_cycle_counter #(
        .FULL_DIV(FULL_DIV), .SLOW_DIV(SLOW_DIV), .DEEP_DIV(DEEP_DIV)
    ) u_cnt (
        .clk(clk), .rst(rst), .req_rate(cfg.mode), .stb(mcyc_stb)
    );

    assign cur_mode  = cfg.mode;
    assign ret_armed = cfg.ret_en;

    assert_reset_state_R1: assert property (@(posedge clk)
        $past(rst) |-> (cur_mode == 2'b00 && !ret_armed));
endmodule

// File: tb/cycle_rate_divider_bench.sv
module cycle_rate_divider_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cfg_we = 1'b0;
    logic [3:0] cfg_wdata = '0;
    logic [1:0] ext_irq = '0;
    logic       rxd = 1'b1;
    logic       mcyc_stb;
    logic [1:0] cur_mode;
    logic       ret_armed;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    cycle_rate_divider u_cycle_rate_divider (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .ext_irq(ext_irq), .rxd(rxd), .mcyc_stb(mcyc_stb),
        .cur_mode(cur_mode), .ret_armed(ret_armed)
    );

    task automatic check(string req, int actual, int expected);
        checks++;
        if (actual != expected) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, actual, expected);
        end
    endtask

    task automatic write_cfg(bit rxw, bit ret, logic [1:0] mode);
        cfg_we    = 1'b1;
        cfg_wdata = {rxw, ret, mode};
        @(negedge clk);
        cfg_we    = 1'b0;
    endtask

    task automatic wait_stb();
        int k = 0;
        @(negedge clk);
        while (!mcyc_stb && k < 1000) begin
            @(negedge clk);
            k++;
        end
    endtask

    task automatic measure(output int p);
        wait_stb();
        p = 0;
        do begin
            @(negedge clk);
            p++;
        end while (!mcyc_stb && p < 1000);
    endtask

    function automatic int expect_div(logic [1:0] code);
        return (code == 2'b10) ? 64 : (code == 2'b11) ? 256 : 4;
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int p;
        int c;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        check("R1 mode", cur_mode, 0);
        check("R1 armed", ret_armed, 0);
        check("R1 strobe low", mcyc_stb, 0);
        measure(p);
        check("R1 period", p, 4);

        // R2 R3 R4: sweep every mode code
        for (int m = 0; m < 4; m++) begin
            write_cfg(1'b0, 1'b0, 2'(m));
            wait_stb();
            measure(p);
            check(m == 2 ? "R3 period" : m == 3 ? "R4 period" : "R2 period",
                  p, expect_div(2'(m)));
        end

        // R5: write mid-cycle in deep mode, cycle must complete at 256
        write_cfg(1'b0, 1'b0, 2'b11);
        wait_stb();
        wait_stb();
        c = 0;
        repeat (10) begin @(negedge clk); c++; end
        write_cfg(1'b0, 1'b0, 2'b00);
        c++;
        while (!mcyc_stb && c < 1000) begin @(negedge clk); c++; end
        check("R5 current cycle kept", c, 256);
        measure(p);
        check("R5 new period", p, 4);

        // R6 R8: interrupt return
        write_cfg(1'b0, 1'b1, 2'b11);
        wait_stb();
        repeat (5) @(negedge clk);
        ext_irq = 2'b10;
        @(negedge clk);
        ext_irq = 2'b00;
        check("R6 mode cleared", cur_mode, 0);
        check("R8 enable kept", ret_armed, 1);
        wait_stb();
        measure(p);
        check("R6 period", p, 4);

        // R6: other interrupt line from slow mode
        write_cfg(1'b0, 1'b1, 2'b10);
        ext_irq = 2'b01;
        @(negedge clk);
        ext_irq = 2'b00;
        check("R6 line0 cleared", cur_mode, 0);

        // R9: disarmed, interrupt ignored
        write_cfg(1'b0, 1'b0, 2'b10);
        ext_irq = 2'b11;
        @(negedge clk);
        ext_irq = 2'b00;
        @(negedge clk);
        check("R9 irq ignored", cur_mode, 2);

        // R7: receive start bit
        write_cfg(1'b1, 1'b1, 2'b11);
        rxd = 1'b0;
        repeat (2) @(negedge clk);
        check("R7 not before sync", cur_mode, 3);
        @(negedge clk);
        check("R7 mode cleared", cur_mode, 0);
        check("R8 enable kept rx", ret_armed, 1);

        // R7: rising edge does nothing
        write_cfg(1'b1, 1'b1, 2'b11);
        repeat (4) @(negedge clk);
        rxd = 1'b1;
        repeat (6) @(negedge clk);
        check("R7 rising ignored", cur_mode, 3);

        // R9: watching off, falling edge ignored
        write_cfg(1'b0, 1'b1, 2'b11);
        rxd = 1'b0;
        repeat (6) @(negedge clk);
        check("R9 rx unwatched", cur_mode, 3);
        rxd = 1'b1;

        // R9: armed off, watched falling edge ignored
        repeat (4) @(negedge clk);
        write_cfg(1'b1, 1'b0, 2'b10);
        rxd = 1'b0;
        repeat (6) @(negedge clk);
        check("R9 rx disarmed", cur_mode, 2);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule